// File: doc/BRIEF.md
# Modulo Timer with Capture/Compare Channels

This block is a free-running up-counter that wraps at a value held in a modulo register. Two channels sit beside it. Each channel either latches the counter when a chosen edge appears on its input pin, or toggles its output pin when the counter equals the channel's value register. An overflow flag and one flag per channel record events. Each flag has an enable bit, and the enabled flags are ORed onto a single interrupt line.

The CPU reaches the block through a small register bus. Writes take one clock. Read data is combinational from the registers. Two power-mode inputs shape the block's behaviour. With `wait_mode` high, the counter and channels keep working and enabled interrupts still reach `irq`, so the processor can be woken; bus reads return zero and bus writes are dropped. With `stop_mode` high, counting, edge sampling and compare matching all halt, and every register, the counter value and the output pins are held. Counting then resumes from the held value once stop ends. The register bus stays usable during stop. The source that ends stop lies outside the block.

Register map (word addresses, `CNT_W`-bit data): 0 = timer control, 1 = counter, 2 = modulo, 3 + 2·i = channel i control, 4 + 2·i = channel i value. In every control register, bit 0 is the interrupt enable and bit 1 is the flag. A channel control register also holds the mode in bit 2 (0 capture, 1 compare) and the edge select in bits 4:3 (bit 3 rising, bit 4 falling; 01 rising, 10 falling, 11 both, 00 none).

Top module: `mod_timer`

## Requirements
- R1: On each clock with `stop_mode` low, the counter increments. When it equals the modulo value, the next count clock loads 0 instead. A write of any data to address 1 clears the counter to 0.
- R2: The overflow flag (bit 1 at address 0) sets on the clock where the counter reloads from the modulo value to 0. It does not set before that clock.
- R3: `irq` is high exactly when a flag is set and its enable bit (bit 0 of the same control register) is 1, counting the overflow flag and both channel flags.
- R4: A flag clears only when its control register is first read while the flag is 1 and then written with bit 1 = 0. A write without that prior read, or a write with bit 1 = 1, leaves the flag unchanged.
- R5: If a flag's event occurs in the same clock as its clearing write, the flag stays set.
- R6: In capture mode (bit 2 = 0), the channel value register latches the counter on the selected edge of its input pin. The pin passes through a two-flop synchroniser. The latched value is the counter value two clocks after the pin change, and the channel flag sets. An edge that is not selected changes nothing.
- R7: In compare mode (bit 2 = 1), a clock on which the counter equals the channel value toggles `cmp_out[i]` and sets the channel flag. Edges on the input pin are ignored.
- R8: With `wait_mode` high, bus reads return 0 and bus writes have no effect. Counting continues and `irq` still reflects enabled flags.
- R9: With `stop_mode` high, the counter, all registers, flags and output pins hold their values. Counting resumes from the held counter value when stop ends.
- R10: Reset values are: counter 0, modulo all ones, and all control and value registers, flags, pins and `irq` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_mode | input | 1 | Wait mode: bus access blocked, timer runs |
| stop_mode | input | 1 | Stop mode: timer frozen, state held |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, 0 when not reading |
| cap_in | input | NUM_CH | Capture input pins, asynchronous |
| cmp_out | output | NUM_CH | Compare toggle outputs |
| irq | output | 1 | Interrupt request |

## Verification
The counter is driven in bursts of exactly counted clocks, with `stop_mode` gating each burst. Reads are taken while the counter is frozen. This separates a wrap at the modulo value from a plain roll-over, and it shows whether stop truly holds state. Capture is tried with rising, falling and both-edge selects against rising and falling pin changes. Each result shows whether the edge filter and the two-clock synchroniser latency are right. Flag clearing is tried with no prior read, with a written 1, with the proper read-then-write, and with a write landing on the overflow clock. Compare is run across a wrap so that the second toggle is seen.

// File: rtl/mod_timer_pkg.sv
package mod_timer_pkg;
    // register word addresses
    localparam int ADDR_CTRL    = 0;
    localparam int ADDR_COUNT   = 1;
    localparam int ADDR_MOD     = 2;
    localparam int ADDR_CH_BASE = 3;

    // bit positions inside every control register
    localparam int BIT_IE    = 0;
    localparam int BIT_FLAG  = 1;
    localparam int BIT_MODE  = 2;
    localparam int BIT_ERISE = 3;
    localparam int BIT_EFALL = 4;

    typedef enum logic {
        CH_CAPTURE = 1'b0,
        CH_COMPARE = 1'b1
    } ch_mode_e;
endpackage

// File: rtl/mod_timer_counter.sv
module mod_timer_counter
    import mod_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr_ctrl,
    input  logic             rd_ctrl,
    input  logic             wr_cnt,
    input  logic             wr_mod,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] mod_o,
    output logic             flag_o,
    output logic             ie_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] modv;
        logic             flag;
        logic             ie;
        logic             arm;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    wrap_evt;

    always_comb begin
        st_d     = st_q;
        wrap_evt = run && (st_q.cnt == st_q.modv);
        if (run) begin
            st_d.cnt = wrap_evt ? '0 : st_q.cnt + 1'b1;
        end
        if (wr_cnt) begin
            st_d.cnt = '0;
        end
        if (wr_mod) begin
            st_d.modv = wdata;
        end
        if (rd_ctrl && st_q.flag) begin
            st_d.arm = 1'b1;
        end
        if (wr_ctrl) begin
            st_d.ie  = wdata[BIT_IE];
            st_d.arm = 1'b0;
            if (st_q.arm && !wdata[BIT_FLAG]) begin
                st_d.flag = 1'b0;
            end
        end
        if (wrap_evt) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.modv <= '1;
            st_q.flag <= 1'b0;
            st_q.ie   <= 1'b0;
            st_q.arm  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign mod_o  = st_q.modv;
    assign flag_o = st_q.flag;
    assign ie_o   = st_q.ie;
endmodule

// File: rtl/mod_timer_chan.sv
module mod_timer_chan
    import mod_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic             pin_in,
    input  logic             wr_ctrl,
    input  logic             rd_ctrl,
    input  logic             wr_val,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] ctrl_o,
    output logic [CNT_W-1:0] val_o,
    output logic             pin_out,
    output logic             flag_o,
    output logic             ie_o
);
    localparam int CTRL_USED = BIT_EFALL + 1;

    typedef struct packed {
        logic [1:0]       sync;
        logic             prev;
        logic             ie;
        logic             flag;
        ch_mode_e         mode;
        logic             e_rise;
        logic             e_fall;
        logic [CNT_W-1:0] val;
        logic             out;
        logic             arm;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   rise, fall, cap_evt, cmp_evt;

    always_comb begin
        st_d    = st_q;
        rise    = st_q.sync[1] && !st_q.prev;
        fall    = !st_q.sync[1] && st_q.prev;
        cap_evt = run && (st_q.mode == CH_CAPTURE)
                  && ((rise && st_q.e_rise) || (fall && st_q.e_fall));
        cmp_evt = run && (st_q.mode == CH_COMPARE) && (cnt == st_q.val);

        if (run) begin
            st_d.sync = {st_q.sync[0], pin_in};
            st_d.prev = st_q.sync[1];
        end
        if (wr_val) begin
            st_d.val = wdata;
        end
        if (rd_ctrl && st_q.flag) begin
            st_d.arm = 1'b1;
        end
        if (wr_ctrl) begin
            st_d.ie     = wdata[BIT_IE];
            st_d.mode   = ch_mode_e'(wdata[BIT_MODE]);
            st_d.e_rise = wdata[BIT_ERISE];
            st_d.e_fall = wdata[BIT_EFALL];
            st_d.arm    = 1'b0;
            if (st_q.arm && !wdata[BIT_FLAG]) begin
                st_d.flag = 1'b0;
            end
        end
        if (cap_evt) begin
            st_d.val  = cnt;
            st_d.flag = 1'b1;
        end
        if (cmp_evt) begin
            st_d.out  = !st_q.out;
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync   <= '0;
            st_q.prev   <= 1'b0;
            st_q.ie     <= 1'b0;
            st_q.flag   <= 1'b0;
            st_q.mode   <= CH_CAPTURE;
            st_q.e_rise <= 1'b0;
            st_q.e_fall <= 1'b0;
            st_q.val    <= '0;
            st_q.out    <= 1'b0;
            st_q.arm    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o  = CNT_W'({st_q.e_fall, st_q.e_rise, st_q.mode, st_q.flag, st_q.ie});
    assign val_o   = st_q.val;
    assign pin_out = st_q.out;
    assign flag_o  = st_q.flag;
    assign ie_o    = st_q.ie;

    initial begin
        if (CNT_W < CTRL_USED) $error("CNT_W too small for control fields");
    end
endmodule

// File: rtl/mod_timer.sv
module mod_timer
    import mod_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = $clog2(ADDR_CH_BASE + 2 * NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wait_mode,
    input  logic              stop_mode,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [NUM_CH-1:0] cap_in,
    output logic [NUM_CH-1:0] cmp_out,
    output logic              irq
);
    logic             run, rd_en, wr_en;
    logic [CNT_W-1:0] cnt_q, mod_q;
    logic             ovf_flag, ovf_ie;
    logic [NUM_CH-1:0] ch_flag, ch_ie;
    logic [CNT_W-1:0] ch_ctrl [NUM_CH];
    logic [CNT_W-1:0] ch_val  [NUM_CH];

    assign run   = !stop_mode;
    assign rd_en = bus_sel && !bus_wr && !wait_mode;
    assign wr_en = bus_sel && bus_wr && !wait_mode;

    mod_timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .wr_ctrl (wr_en && (bus_addr == ADDR_W'(ADDR_CTRL))),
        .rd_ctrl (rd_en && (bus_addr == ADDR_W'(ADDR_CTRL))),
        .wr_cnt  (wr_en && (bus_addr == ADDR_W'(ADDR_COUNT))),
        .wr_mod  (wr_en && (bus_addr == ADDR_W'(ADDR_MOD))),
        .wdata   (bus_wdata),
        .cnt_o   (cnt_q),
        .mod_o   (mod_q),
        .flag_o  (ovf_flag),
        .ie_o    (ovf_ie)
    );

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        localparam int CTRL_A = ADDR_CH_BASE + 2 * gi;
        localparam int VAL_A  = CTRL_A + 1;
        mod_timer_chan #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run),
            .cnt     (cnt_q),
            .pin_in  (cap_in[gi]),
            .wr_ctrl (wr_en && (bus_addr == ADDR_W'(CTRL_A))),
            .rd_ctrl (rd_en && (bus_addr == ADDR_W'(CTRL_A))),
            .wr_val  (wr_en && (bus_addr == ADDR_W'(VAL_A))),
            .wdata   (bus_wdata),
            .ctrl_o  (ch_ctrl[gi]),
            .val_o   (ch_val[gi]),
            .pin_out (cmp_out[gi]),
            .flag_o  (ch_flag[gi]),
            .ie_o    (ch_ie[gi])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            if (bus_addr == ADDR_W'(ADDR_CTRL)) begin
                bus_rdata = CNT_W'({ovf_flag, ovf_ie});
            end
            if (bus_addr == ADDR_W'(ADDR_COUNT)) begin
                bus_rdata = cnt_q;
            end
            if (bus_addr == ADDR_W'(ADDR_MOD)) begin
                bus_rdata = mod_q;
            end
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_addr == ADDR_W'(ADDR_CH_BASE + 2 * i)) begin
                    bus_rdata = ch_ctrl[i];
                end
                if (bus_addr == ADDR_W'(ADDR_CH_BASE + 2 * i + 1)) begin
                    bus_rdata = ch_val[i];
                end
            end
        end
    end

    assign irq = (ovf_flag && ovf_ie) || |(ch_flag & ch_ie);
endmodule

// File: rtl/mod_timer_sva.sv
module mod_timer_sva #(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wait_mode,
    input logic              stop_mode,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_rdata,
    input logic [NUM_CH-1:0] cmp_out,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  mod_q,
    input logic              ovf_flag,
    input logic              ovf_ie,
    input logic [NUM_CH-1:0] ch_ie
);
    logic cnt_wr, ctrl_wr;
    assign cnt_wr  = bus_sel && bus_wr && !wait_mode && (bus_addr == ADDR_W'(1));
    assign ctrl_wr = bus_sel && bus_wr && !wait_mode && (bus_addr == ADDR_W'(0));

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_mode && (cnt_q == mod_q) && !cnt_wr) |=> (cnt_q == '0)); // R1
    AST_OVF_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_mode && (cnt_q == mod_q)) |=> ovf_flag); // R2
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_ie && (ch_ie == '0)) |-> !irq); // R3
    AST_FLAG_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ctrl_wr) |=> ovf_flag); // R4
    AST_WAIT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wait_mode |-> (bus_rdata == '0)); // R8
    AST_STOP_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && !cnt_wr) |=> $stable(cnt_q)); // R9
    AST_STOP_HOLDS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |=> $stable(cmp_out)); // R9
endmodule

bind mod_timer mod_timer_sva #(
    .CNT_W  (CNT_W),
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .wait_mode (wait_mode),
    .stop_mode (stop_mode),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .cmp_out   (cmp_out),
    .irq       (irq),
    .cnt_q     (cnt_q),
    .mod_q     (mod_q),
    .ovf_flag  (ovf_flag),
    .ovf_ie    (ovf_ie),
    .ch_ie     (ch_ie)
);

// File: tb/mod_timer_tb_top.sv
`timescale 1ns/1ps
module mod_timer_tb_top;
    localparam int CNT_W  = 16;
    localparam int NUM_CH = 2;
    localparam int ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wait_mode = 1'b0;
    logic              stop_mode = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [CNT_W-1:0]  bus_wdata = '0;
    logic [CNT_W-1:0]  bus_rdata;
    logic [NUM_CH-1:0] cap_in = '0;
    logic [NUM_CH-1:0] cmp_out;
    logic              irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        int         kind; // 0 read data, 1 cmp_out, 2 irq
        logic [15:0] exp;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    mod_timer #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wait_mode(wait_mode), .stop_mode(stop_mode),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_in(cap_in), .cmp_out(cmp_out), .irq(irq)
    );

    // monitor: compare every pending expectation at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [15:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = 16'(cmp_out);
                default: act = 16'(irq);
            endcase
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input logic [15:0] e, input string req);
        sb_item_t it;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(a);
        it.req = req; it.kind = 0; it.exp = e;
        sb_q.push_back(it);
        tick();
        bus_sel = 1'b0;
    endtask

    task automatic pin(input int kind, input logic [15:0] e, input string req);
        sb_item_t it;
        it.req = req; it.kind = kind; it.exp = e;
        sb_q.push_back(it);
        tick();
    endtask

    task automatic run(input int k);
        stop_mode = 1'b0;
        repeat (k) tick();
        stop_mode = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R10 reset values
        rd(0, 16'h0, "R10 ctrl"); rd(1, 16'h0, "R10 count"); rd(2, 16'hFFFF, "R10 modulo");
        rd(3, 16'h0, "R10 ch0 ctrl"); rd(4, 16'h0, "R10 ch0 val");
        rd(5, 16'h0, "R10 ch1 ctrl"); rd(6, 16'h0, "R10 ch1 val");
        pin(1, 16'h0, "R10 cmp_out"); pin(2, 16'h0, "R10 irq");
        // R1 / R2 wrap at modulo
        wr(2, 16'd9);
        run(7);
        rd(1, 16'd7, "R1 count mid"); rd(0, 16'h0, "R2 flag not yet");
        run(3);
        rd(1, 16'd0, "R1 wrap to zero"); rd(0, 16'h2, "R2 flag set");
        // R3 / R4 enable and clearing
        pin(2, 16'h0, "R3 irq disabled");
        wr(0, 16'h3);
        pin(2, 16'h1, "R3 irq enabled");
        wr(0, 16'h1);
        rd(0, 16'h3, "R4 write without read");
        wr(0, 16'h3);
        rd(0, 16'h3, "R4 write of one");
        wr(0, 16'h1);
        rd(0, 16'h1, "R4 read then clear");
        pin(2, 16'h0, "R3 irq after clear");
        // R5 clear collides with overflow
        wr(1, 16'h0);
        run(10);
        run(9);
        rd(1, 16'd9, "R1 at modulo");
        rd(0, 16'h3, "R5 arm");
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h1; stop_mode = 1'b0;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0; stop_mode = 1'b1;
        rd(0, 16'h3, "R5 event wins");
        rd(1, 16'd0, "R1 reload in collision");
        // R8 wait mode
        wait_mode = 1'b1;
        rd(0, 16'h0, "R8 read blocked");
        wr(2, 16'd3);
        pin(2, 16'h1, "R8 irq passes");
        wait_mode = 1'b0;
        rd(2, 16'd9, "R8 write ignored");
        wait_mode = 1'b1;
        run(4);
        wait_mode = 1'b0;
        rd(1, 16'd4, "R8 counts in wait");
        // R9 stop holds
        repeat (20) tick();
        rd(1, 16'd4, "R9 stop holds count");
        // R6 capture
        wr(0, 16'h0);
        wr(2, 16'hFFFF);
        wr(1, 16'h0);
        wr(3, 16'h0009);
        cap_in[0] = 1'b1;
        run(5);
        rd(4, 16'd2, "R6 rising capture");
        rd(3, 16'h000B, "R6 capture flag");
        pin(2, 16'h1, "R3 channel irq");
        rd(1, 16'd5, "R9 resumes count");
        cap_in[0] = 1'b0;
        run(5);
        rd(4, 16'd2, "R6 falling ignored");
        wr(3, 16'h0019);
        cap_in[0] = 1'b1;
        run(5);
        rd(4, 16'd12, "R6 both rising");
        wr(3, 16'h0011);
        cap_in[0] = 1'b0;
        run(5);
        rd(4, 16'd17, "R6 falling capture");
        rd(3, 16'h0013, "R6 falling flag");
        wr(3, 16'h0011);
        rd(3, 16'h0011, "R4 channel clear");
        pin(2, 16'h0, "R3 irq channel cleared");
        // R7 compare
        wr(1, 16'h0);
        wr(6, 16'd3);
        wr(5, 16'h0004);
        run(3);
        pin(1, 16'h0, "R7 before match");
        run(1);
        pin(1, 16'h2, "R7 toggle on match");
        rd(5, 16'h0006, "R7 compare flag");
        pin(2, 16'h0, "R3 compare irq disabled");
        wr(2, 16'd4);
        run(5);
        pin(1, 16'h0, "R7 second toggle after wrap");
        cap_in[1] = 1'b1;
        run(5);
        rd(6, 16'd3, "R7 capture pin ignored");
        tick();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule